// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status flags of an asynchronous serial port and drives its interrupt line. Transmit-side hardware reports when the holding register may move into the shift register and when a frame has finished leaving the pin. Receive-side hardware reports when a received byte has been placed in the readable data register and when the line has gone idle. The block turns these events into sticky flags and combines each flag with its enable into a single interrupt request.

Software clears the flags with a two-step handshake on a small register bus. It first reads the status register, which arms a one-shot latch. The next access to the data register consumes that latch. A write clears the transmit flags and a read clears the receive flags. The four receive error conditions are captured from the receive path when a byte arrives and are cleared together with the receive-ready flag. The idle flag can fire only once per received byte.

Top module: `ser_status_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, the status register reads 0xC0: transmit-empty and transmit-done are 1 and every other bit is 0.
- R2: With `bus_addr` = 0, `bus_rdata` shows the status register. Bit 7 is transmit-empty, bit 6 transmit-done, bit 5 receive-ready and bit 4 idle. Bits 3..0 are the captured `rx_err` vector (overrun, noise, framing, parity). With `bus_addr` = 1, `bus_rdata` shows `rx_byte`.
- R3: `tx_xfer_grant` is high exactly when `tx_xfer_req` is high and transmit-empty is 0. A grant sets transmit-empty at the next edge.
- R4: A status read followed by a data-register write (`bus_addr` = 1, `bus_wr`) clears transmit-empty and transmit-done. A data-register read does not clear them.
- R5: A `tx_frame_done` pulse sets transmit-done only when `tx_frame_kind` is 0 (data). Kind 1 (preamble) and kind 2 (break) leave it unchanged.
- R6: `rx_data_move` sets receive-ready. A status read followed by a data-register read clears it. A data-register write does not clear it.
- R7: `rx_idle_det` sets the idle flag only if `rx_data_move` has occurred since the idle flag was last set, or since reset. The idle flag is cleared by the same read sequence as R6.
- R8: On `rx_data_move`, status bits 3..0 load `rx_err`. The R6 read sequence clears them.
- R9: A status read (`bus_cs`, `bus_rd`, `bus_addr` = 0) arms the clearing latch. The next data-register access consumes it, whether that access is a read or a write. A data-register access without an armed latch clears nothing.
- R10: When a set event and the clearing access for a flag fall in the same cycle, the flag is 1 afterwards. The error bits take the new `rx_err`.
- R11: `irq` is high whenever any of these pairs is high: transmit-empty and `en_tx_empty`, transmit-done and `en_tx_done`, receive-ready and `en_rx_ready`, idle and `en_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = status register, 1 = data register |
| bus_rdata | output | 8 | Read data (status or received byte) |
| rx_byte | input | 8 | Contents of the readable data register |
| tx_xfer_req | input | 1 | Holding register wants to move into the shift register |
| tx_xfer_grant | output | 1 | Move permitted this cycle |
| tx_frame_done | input | 1 | One-cycle pulse at end of a transmitted frame |
| tx_frame_kind | input | 2 | Frame type: 0 data, 1 preamble, 2 break |
| rx_data_move | input | 1 | Received byte moved into data register |
| rx_err | input | 4 | Overrun, noise, framing, parity conditions (bit 3..0) |
| rx_idle_det | input | 1 | Idle line detected |
| en_tx_empty | input | 1 | Interrupt enable for transmit-empty |
| en_tx_done | input | 1 | Interrupt enable for transmit-done |
| en_rx_ready | input | 1 | Interrupt enable for receive-ready |
| en_idle | input | 1 | Interrupt enable for idle |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can land in the same cycle: a flag's hardware set event and the armed data-register access that would clear it. The bench provokes this directly. It issues a status read and then a data read in the same cycle as `rx_data_move`. It also issues a data write in the same cycle as a data-type `tx_frame_done`. Random traffic raises such collisions often. A bench model judges the outcome cycle by cycle: the flag must read 1 on the next status read and the error bits must hold the new vector. Misdirected accesses (a read after arming when the transmit flags are set) are judged the same way.

// File: rtl/ser_flag_pkg.sv
// Package: shared constants and types for the serial status flag controller.
// Assumes an 8-bit status register with the flag order decoded by software.
package ser_flag_pkg;
    parameter int STAT_W = 8;
    parameter int ERR_W  = 4;

    // Status bit positions (software decodes these).
    localparam int BIT_TX_EMPTY = 7;
    localparam int BIT_TX_DONE  = 6;
    localparam int BIT_RX_READY = 5;
    localparam int BIT_IDLE     = 4;

    // Register select values on the bus address line.
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_DATA   = 1'b1;

    // Kind of frame reported by the transmit path at frame end.
    typedef enum logic [1:0] {
        FK_DATA     = 2'd0,
        FK_PREAMBLE = 2'd1,
        FK_BREAK    = 2'd2,
        FK_RSVD     = 2'd3
    } frame_kind_e;
endpackage

// File: rtl/ser_bus_seq.sv
// Module: decodes bus accesses and tracks the status-read latch that enables
// flag clearing. Assumes strobes are single-cycle qualified by bus_cs.
module ser_bus_seq
    import ser_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cs,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_addr,
    output logic clr_tx,
    output logic clr_rx
);
    logic stat_rd;
    logic data_rd;
    logic data_wr;
    logic armed_q;

    // Decode the three access types of interest.
    always_comb begin
        stat_rd = bus_cs && bus_rd && (bus_addr == ADDR_STATUS);
        data_rd = bus_cs && bus_rd && (bus_addr == ADDR_DATA);
        data_wr = bus_cs && bus_wr && (bus_addr == ADDR_DATA);
    end

    // Arm on a status read, disarm on any data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (stat_rd) begin
            armed_q <= 1'b1;
        end else if (data_rd || data_wr) begin
            armed_q <= 1'b0;
        end
    end

    // Direction of the consuming access selects which flags clear.
    always_comb begin
        clr_tx = armed_q && data_wr;
        clr_rx = armed_q && data_rd;
    end
endmodule

// File: rtl/ser_tx_flags.sv
// Module: transmit-empty and transmit-done flags plus the holding-to-shift
// transfer gate. Assumes tx_frame_done is a one-cycle pulse.
module ser_tx_flags
    import ser_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_tx,
    input  logic       xfer_req,
    input  logic       frame_done,
    input  logic [1:0] frame_kind,
    output logic       xfer_grant,
    output logic       tx_empty,
    output logic       tx_done
);
    logic data_frame_end;

    // The transfer may only happen once software has refilled the holder.
    always_comb begin
        xfer_grant     = xfer_req && !tx_empty;
        data_frame_end = frame_done && (frame_kind == FK_DATA);
    end

    // Transmit-empty: set by a granted transfer, cleared by the write sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b1;
        end else if (xfer_grant) begin
            tx_empty <= 1'b1;
        end else if (clr_tx) begin
            tx_empty <= 1'b0;
        end
    end

    // Transmit-done: set by a data frame end only, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b1;
        end else if (data_frame_end) begin
            tx_done <= 1'b1;
        end else if (clr_tx) begin
            tx_done <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_rx_flags.sv
// Module: receive-ready, idle and captured error flags. Assumes the idle
// detector may pulse repeatedly on a quiet line; only one set per reception.
module ser_rx_flags
    import ser_flag_pkg::*;
#(
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_rx,
    input  logic          data_move,
    input  logic [EW-1:0] err_in,
    input  logic          idle_det,
    output logic          rx_ready,
    output logic          idle,
    output logic [EW-1:0] err_q
);
    logic idle_ok_q;
    logic idle_set;

    // Idle may fire only after a reception since its last firing.
    always_comb idle_set = idle_det && idle_ok_q;

    // Receive-ready: set on data move, cleared by the read sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
        end else if (data_move) begin
            rx_ready <= 1'b1;
        end else if (clr_rx) begin
            rx_ready <= 1'b0;
        end
    end

    // Re-arm tracker for the idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_ok_q <= 1'b0;
        end else if (data_move) begin
            idle_ok_q <= 1'b1;
        end else if (idle_set) begin
            idle_ok_q <= 1'b0;
        end
    end

    // Idle flag: set when permitted, cleared by the read sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle <= 1'b0;
        end else if (idle_set) begin
            idle <= 1'b1;
        end else if (clr_rx) begin
            idle <= 1'b0;
        end
    end

    // Error conditions captured alongside each received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (data_move) begin
            err_q <= err_in;
        end else if (clr_rx) begin
            err_q <= '0;
        end
    end
endmodule

// File: rtl/ser_irq_merge.sv
// Module: ANDs each flag with its enable and ORs the results into one request.
// Assumes flags and enables share bit ordering.
module ser_irq_merge #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    output logic            irq
);
    logic [NSRC-1:0] hit;

    // One gated term per source.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = flags[i] & enables[i];
    end

    // Any gated term raises the request.
    always_comb irq = |hit;
endmodule

// File: rtl/ser_status_ctrl.sv
// Module: top of the serial status flag controller. Assembles the bus
// sequencer, flag banks and interrupt merge. Read data is combinational.
module ser_status_ctrl
    import ser_flag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int EW     = ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_addr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_xfer_req,
    output logic              tx_xfer_grant,
    input  logic              tx_frame_done,
    input  logic [1:0]        tx_frame_kind,
    input  logic              rx_data_move,
    input  logic [EW-1:0]     rx_err,
    input  logic              rx_idle_det,
    input  logic              en_tx_empty,
    input  logic              en_tx_done,
    input  logic              en_rx_ready,
    input  logic              en_idle,
    output logic              irq
);
    localparam int NSRC = 4;

    logic          clr_tx;
    logic          clr_rx;
    logic          tx_empty;
    logic          tx_done;
    logic          rx_ready;
    logic          idle;
    logic [EW-1:0] err_q;
    logic [STAT_W-1:0] status_w;

    ser_bus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs   (bus_cs),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .clr_tx   (clr_tx),
        .clr_rx   (clr_rx)
    );

    ser_tx_flags u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_tx     (clr_tx),
        .xfer_req   (tx_xfer_req),
        .frame_done (tx_frame_done),
        .frame_kind (tx_frame_kind),
        .xfer_grant (tx_xfer_grant),
        .tx_empty   (tx_empty),
        .tx_done    (tx_done)
    );

    ser_rx_flags #(.EW(EW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_rx    (clr_rx),
        .data_move (rx_data_move),
        .err_in    (rx_err),
        .idle_det  (rx_idle_det),
        .rx_ready  (rx_ready),
        .idle      (idle),
        .err_q     (err_q)
    );

    ser_irq_merge #(.NSRC(NSRC)) u_irq (
        .flags   ({tx_empty, tx_done, rx_ready, idle}),
        .enables ({en_tx_empty, en_tx_done, en_rx_ready, en_idle}),
        .irq     (irq)
    );

    // Assemble the status word in its fixed bit order.
    always_comb begin
        status_w               = '0;
        status_w[BIT_TX_EMPTY] = tx_empty;
        status_w[BIT_TX_DONE]  = tx_done;
        status_w[BIT_RX_READY] = rx_ready;
        status_w[BIT_IDLE]     = idle;
        status_w[EW-1:0]       = err_q;
    end

    // Register select for read data.
    always_comb bus_rdata = (bus_addr == ADDR_DATA) ? rx_byte : status_w;
endmodule

// File: rtl/ser_status_chk.sv
// Module: property checker bound to the top; observes status and strobes.
module ser_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       bus_cs,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic       tx_xfer_grant,
    input logic       tx_frame_done,
    input logic [1:0] tx_frame_kind,
    input logic       rx_data_move
);
    // R1
    reset_value_chk: assert property (@(posedge clk) !rst_n |=> status == 8'hC0);

    // R3
    grant_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_xfer_grant |=> status[7]);

    // R5
    odd_frame_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frame_done && tx_frame_kind != 2'd0 && !status[6]) |=> !status[6]);

    // R10
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_move |=> status[5]);

    // R6
    write_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && !bus_rd && bus_addr && status[5]) |=> status[5]);

    // R4
    read_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd && !bus_wr && bus_addr && status[7]) |=> status[7]);
endmodule

bind ser_status_ctrl ser_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .status        (status_w),
    .bus_cs        (bus_cs),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .tx_xfer_grant (tx_xfer_grant),
    .tx_frame_done (tx_frame_done),
    .tx_frame_kind (tx_frame_kind),
    .rx_data_move  (rx_data_move)
);

// File: tb/ser_status_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases and seeded random traffic against a flag model.
module ser_status_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 0, bus_rd = 0, bus_wr = 0, bus_addr = 0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_xfer_req = 0;
    logic       tx_xfer_grant;
    logic       tx_frame_done = 0;
    logic [1:0] tx_frame_kind = 0;
    logic       rx_data_move = 0;
    logic [3:0] rx_err = 0;
    logic       rx_idle_det = 0;
    logic       en_tx_empty = 0, en_tx_done = 0, en_rx_ready = 0, en_idle = 0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state
    bit m_te, m_tc, m_rr, m_id, m_arm, m_idok;
    bit [3:0] m_err;

    always #2.5 clk = ~clk;

    ser_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .rx_byte(rx_byte), .tx_xfer_req(tx_xfer_req), .tx_xfer_grant(tx_xfer_grant),
        .tx_frame_done(tx_frame_done), .tx_frame_kind(tx_frame_kind),
        .rx_data_move(rx_data_move), .rx_err(rx_err), .rx_idle_det(rx_idle_det),
        .en_tx_empty(en_tx_empty), .en_tx_done(en_tx_done),
        .en_rx_ready(en_rx_ready), .en_idle(en_idle), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        return {m_te, m_tc, m_rr, m_id, m_err};
    endfunction

    function automatic logic exp_irq();
        return (m_te & en_tx_empty) | (m_tc & en_tx_done) |
               (m_rr & en_rx_ready) | (m_id & en_idle);
    endfunction

    task automatic model_reset();
        m_te = 1; m_tc = 1; m_rr = 0; m_id = 0; m_arm = 0; m_idok = 0; m_err = 0;
    endtask

    // Next-state of the model from the inputs applied this cycle.
    task automatic model_step();
        bit srd, drd, dwr, ctx, crx, gr, idset;
        srd = bus_cs & bus_rd & !bus_addr;
        drd = bus_cs & bus_rd & bus_addr;
        dwr = bus_cs & bus_wr & bus_addr;
        ctx = m_arm & dwr;
        crx = m_arm & drd;
        gr  = tx_xfer_req & !m_te;
        idset = rx_idle_det & m_idok;
        if (gr) m_te = 1; else if (ctx) m_te = 0;
        if (tx_frame_done && tx_frame_kind == 2'd0) m_tc = 1; else if (ctx) m_tc = 0;
        if (rx_data_move) m_rr = 1; else if (crx) m_rr = 0;
        if (idset) m_id = 1; else if (crx) m_id = 0;
        if (rx_data_move) m_err = rx_err; else if (crx) m_err = 0;
        if (rx_data_move) m_idok = 1; else if (idset) m_idok = 0;
        if (srd) m_arm = 1; else if (drd | dwr) m_arm = 0;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Check outputs for the inputs just applied, then advance one cycle.
    task automatic tick(string tag);
        logic [7:0] erd;
        #1;
        erd = bus_addr ? rx_byte : exp_status();
        chk(tag, bus_rdata, erd);
        chk("R11", {7'd0, irq}, {7'd0, exp_irq()});
        chk("R3", {7'd0, tx_xfer_grant}, {7'd0, tx_xfer_req & !m_te});
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        bus_cs = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0;
        tx_xfer_req = 0; tx_frame_done = 0; tx_frame_kind = 0;
        rx_data_move = 0; rx_idle_det = 0;
    endtask

    task automatic stat_rd(string tag);
        quiet(); bus_cs = 1; bus_rd = 1; bus_addr = 0; tick(tag);
    endtask
    task automatic data_rd(string tag);
        quiet(); bus_cs = 1; bus_rd = 1; bus_addr = 1; tick(tag);
    endtask
    task automatic data_wr(string tag);
        quiet(); bus_cs = 1; bus_wr = 1; bus_addr = 1; tick(tag);
    endtask
    task automatic look(string tag);
        quiet(); tick(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset value
        look("R1");
        // R2: data address shows received byte
        rx_byte = 8'h5A; quiet(); bus_addr = 1; tick("R2");
        // R3: transfer blocked while transmit-empty is set
        quiet(); tx_xfer_req = 1; tick("R3");
        // R9: data write without status read clears nothing
        data_wr("R9"); look("R9");
        // R4: status read then data read keeps transmit flags
        stat_rd("R4"); data_rd("R4"); look("R4");
        // R4: status read then data write clears them
        stat_rd("R4"); data_wr("R4"); look("R4");
        // R3: transfer now granted and empty sets again
        quiet(); tx_xfer_req = 1; tick("R3"); look("R3");
        // R5: preamble and break do not set done; data does
        quiet(); tx_frame_done = 1; tx_frame_kind = 2'd1; tick("R5"); look("R5");
        quiet(); tx_frame_done = 1; tx_frame_kind = 2'd2; tick("R5"); look("R5");
        quiet(); tx_frame_done = 1; tx_frame_kind = 2'd0; tick("R5"); look("R5");
        // R7: idle without prior reception stays clear
        quiet(); rx_idle_det = 1; tick("R7"); look("R7");
        // R6/R8: reception with error bits
        quiet(); rx_data_move = 1; rx_err = 4'b1010; tick("R8"); look("R8");
        stat_rd("R6"); data_wr("R6"); look("R6");
        // R7: idle now allowed once
        quiet(); rx_idle_det = 1; tick("R7"); look("R7");
        stat_rd("R6"); data_rd("R6"); look("R8");
        quiet(); rx_idle_det = 1; tick("R7"); look("R7");
        // R10: set in the clearing cycle wins (receive side)
        quiet(); rx_data_move = 1; rx_err = 4'b0101; tick("R10");
        stat_rd("R10");
        quiet(); bus_cs = 1; bus_rd = 1; bus_addr = 1; rx_data_move = 1; rx_err = 4'b0011;
        tick("R10"); look("R10");
        // R10: transmit side
        stat_rd("R10");
        quiet(); bus_cs = 1; bus_wr = 1; bus_addr = 1; tx_frame_done = 1; tick("R10");
        look("R10");
        // R11: each enable alone
        en_tx_done = 1; look("R11"); en_tx_done = 0;
        en_rx_ready = 1; look("R11"); en_rx_ready = 0;
        en_tx_empty = 1; look("R11"); en_tx_empty = 0;
        en_idle = 1; look("R11"); en_idle = 0;
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            quiet();
            bus_cs       = ($urandom % 3) != 0;
            bus_rd       = $urandom % 2;
            bus_wr       = $urandom % 2;
            bus_addr     = $urandom % 2;
            rx_byte      = 8'($urandom);
            tx_xfer_req  = ($urandom % 4) == 0;
            tx_frame_done = ($urandom % 5) == 0;
            tx_frame_kind = 2'($urandom);
            rx_data_move = ($urandom % 6) == 0;
            rx_err       = 4'($urandom);
            rx_idle_det  = ($urandom % 4) == 0;
            en_tx_empty  = $urandom % 2;
            en_tx_done   = $urandom % 2;
            en_rx_ready  = $urandom % 2;
            en_idle      = $urandom % 2;
            tick(bus_addr ? "R2" : "R10");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule